// File: doc/BRIEF.md
# LCD Frame Control Register

This block is the single 8-bit control and status register of a segment LCD driver. A CPU reaches it over a simple register bus. `bus_sel` selects the register. `bus_wr` writes `bus_wdata`. `bus_rd` together with `bus_sel` puts the register contents on `bus_rdata`. When the register is not being read, `bus_rdata` is zero.

The LCD timing generator supplies a one-cycle `frame_start` pulse. This pulse is the frame boundary. The block uses it to release held mode changes to the driver, and it also sets the frame interrupt flag. The driver enable acts at once. The low-power waveform select and the blanking request are held back: they reach the driver only at the next frame boundary. The frame flag can raise an interrupt request. Software clears the flag by writing a one to it, or the interrupt controller clears it with `irq_ack`.

In this document, "frame start" means a cycle in which `frame_start` is high while the driver is enabled. A `frame_start` pulse while the driver is disabled is ignored.

Top module: `lcd_frame_ctrl`

## Requirements
- R1: After reset every register bit is zero. Reading the register returns 0x00, and `drv_enable`, `wave_lowpwr`, `blank_out` and `irq` are all 0.
- R2: The register bit positions are: bit 7 enable, bit 6 low-power waveform request, bit 4 frame flag, bit 3 interrupt enable, bit 0 blanking request. Bits 5, 2 and 1 always read as zero and ignore writes. Writing 0xFF to a register holding 0x00 reads back 0xC9.
- R3: `drv_enable` follows the enable bit from the cycle after the write, in both directions. While `drv_enable` is 0, `blank_out` is 0.
- R4: `wave_lowpwr` takes the value of the requested waveform bit only at a frame start. Between frame starts it stays unchanged.
- R5: Every frame start sets the flag, except for the low-power case in R6. `irq` is 1 exactly when the flag, the interrupt enable and `gie` are all 1.
- R6: While `wave_lowpwr` is 1, only every second frame start sets the flag. After low-power mode is entered, or after the driver has been disabled, the first frame start that finds `wave_lowpwr` at 1 does set the flag.
- R7: The flag is cleared by writing a one to bit 4 or by a pulse on `irq_ack`. Writing a zero to bit 4 leaves the flag unchanged.
- R8: If a flag set and a clear (by write or by acknowledge) fall in the same cycle, the flag ends up set.
- R9: `blank_out` takes the value of the blanking request bit, both setting and releasing, only at a frame start.
- R10: A `frame_start` pulse while the driver is disabled sets no flag and changes neither `wave_lowpwr` nor the held blanking state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; zero when the register is not being read |
| frame_start | input | 1 | One-cycle frame boundary pulse from the timing generator |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| gie | input | 1 | Global interrupt enable |
| drv_enable | output | 1 | LCD driver enable |
| wave_lowpwr | output | 1 | Active waveform select; 1 means low-power waveform |
| blank_out | output | 1 | Force all segment and common outputs to ground |
| irq | output | 1 | Frame interrupt request |

## Verification
Two events can land on the frame flag in the same cycle: the hardware set at a frame start, and a software clear, either a write of one to bit 4 or an `irq_ack` pulse. The bench drives `frame_start` in the very cycle of a clearing write, and separately in the very cycle of an acknowledge. After each, it reads the register and expects bit 4 still set. The bench also checks, at the ports, that a mode write made between frame boundaries leaves `wave_lowpwr` and `blank_out` unchanged until the next `frame_start`.

// File: rtl/lcd_frame_ctrl.sv
module lcd_frame_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       frame_start,
  input  logic       irq_ack,
  input  logic       gie,
  output logic       drv_enable,
  output logic       wave_lowpwr,
  output logic       blank_out,
  output logic       irq
);
  logic en_q, lp_req_q, ie_q, blank_req_q;
  logic flag_q, lp_act_q, blank_act_q, skip_q;

  wire wr_hit   = bus_sel & bus_wr;
  wire frame_ev = frame_start & en_q;
  wire flag_set = frame_ev & (~lp_act_q | ~skip_q);
  wire flag_clr = (wr_hit & bus_wdata[4]) | irq_ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      lp_req_q    <= 1'b0;
      ie_q        <= 1'b0;
      blank_req_q <= 1'b0;
    end else if (wr_hit) begin
      en_q        <= bus_wdata[7];
      lp_req_q    <= bus_wdata[6];
      ie_q        <= bus_wdata[3];
      blank_req_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lp_act_q    <= 1'b0;
      blank_act_q <= 1'b0;
    end else if (frame_ev) begin
      lp_act_q    <= lp_req_q;
      blank_act_q <= blank_req_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      skip_q <= 1'b0;
    else if (!en_q)
      skip_q <= 1'b0;
    else if (frame_ev)
      skip_q <= lp_act_q ? ~skip_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag_q <= 1'b0;
    else if (flag_set)
      flag_q <= 1'b1;
    else if (flag_clr)
      flag_q <= 1'b0;
  end

  wire [7:0] reg_view = {en_q, lp_req_q, 1'b0, flag_q, ie_q, 2'b00, blank_req_q};

  assign bus_rdata   = (bus_sel & bus_rd) ? reg_view : 8'h00;
  assign drv_enable  = en_q;
  assign wave_lowpwr = lp_act_q;
  assign blank_out   = blank_act_q & en_q;
  assign irq         = flag_q & ie_q & gie;
endmodule

module lcd_frame_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic frame_start,
  input logic irq_ack,
  input logic gie,
  input logic drv_enable,
  input logic wave_lowpwr,
  input logic blank_out,
  input logic irq,
  input logic ie_q,
  input logic flag_q,
  input logic blank_act_q
);
  a_r3_blank_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_enable |-> !blank_out);

  a_r4_wave_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && drv_enable) |=> $stable(wave_lowpwr));

  a_r9_blank_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_start && drv_enable) |=> $stable(blank_act_q));

  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (gie && ie_q && flag_q));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_ack && !(frame_start && drv_enable)) |=> !flag_q);

  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && drv_enable && !wave_lowpwr) |=> flag_q);

  a_r10_idle_frame: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !drv_enable && !flag_q) |=> !flag_q);
endmodule

bind lcd_frame_ctrl lcd_frame_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .irq_ack(irq_ack),
  .gie(gie), .drv_enable(drv_enable), .wave_lowpwr(wave_lowpwr),
  .blank_out(blank_out), .irq(irq), .ie_q(ie_q), .flag_q(flag_q),
  .blank_act_q(blank_act_q)
);

// File: tb/lcd_frame_ctrl_tb.sv
`timescale 1ns/1ps
module lcd_frame_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic frame_start = 1'b0, irq_ack = 1'b0, gie = 1'b0;
  logic drv_enable, wave_lowpwr, blank_out, irq;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  lcd_frame_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_start(frame_start),
    .irq_ack(irq_ack), .gie(gie), .drv_enable(drv_enable), .wave_lowpwr(wave_lowpwr),
    .blank_out(blank_out), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; gie = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] exp);
    @(negedge clk);
    bus_sel = 1'b1; bus_rd = 1'b1;
    #1 chk(req, bus_rdata, exp);
    bus_sel = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    rd_chk("R1 read", 8'h00);
    chk("R1 outs", {4'h0, drv_enable, wave_lowpwr, blank_out, irq}, 8'h00);
  endtask

  task automatic t_layout_enable();
    do_reset();
    wr(8'hFF);
    rd_chk("R2 layout", 8'hC9);
    chk("R3 enable", {7'h0, drv_enable}, 8'h01);
    chk("R4 wave held", {7'h0, wave_lowpwr}, 8'h00);
    chk("R9 blank held", {7'h0, blank_out}, 8'h00);
    frame();
    chk("R4 wave at frame", {7'h0, wave_lowpwr}, 8'h01);
    chk("R9 blank at frame", {7'h0, blank_out}, 8'h01);
    rd_chk("R5 flag set", 8'hD9);
    chk("R5 irq gie=0", {7'h0, irq}, 8'h00);
    gie = 1'b1;
    #1 chk("R5 irq gie=1", {7'h0, irq}, 8'h01);
    wr(8'h00);
    chk("R3 disable", {6'h0, drv_enable, blank_out}, 8'h00);
    rd_chk("R7 write zero keeps flag", 8'h10);
    wr(8'h10);
    rd_chk("R7 write one clears", 8'h00);
    frame();
    rd_chk("R10 idle frame no flag", 8'h00);
    chk("R10 wave kept", {7'h0, wave_lowpwr}, 8'h01);
  endtask

  task automatic t_lowpower();
    do_reset();
    wr(8'hC0);
    frame();
    rd_chk("R5 normal frame sets", 8'hD0);
    wr(8'hD0);
    frame();
    rd_chk("R6 first lp frame sets", 8'hD0);
    wr(8'hD0);
    frame();
    rd_chk("R6 second lp frame skips", 8'hC0);
    frame();
    rd_chk("R6 third lp frame sets", 8'hD0);
    wr(8'hD0);
    wr(8'h40);
    wr(8'hC0);
    frame();
    rd_chk("R6 first after re-enable sets", 8'hD0);
    wr(8'h90);
    frame();
    rd_chk("R6 skip while leaving lp", 8'h80);
    chk("R4 wave back to normal", {7'h0, wave_lowpwr}, 8'h00);
    frame();
    rd_chk("R5 normal again sets", 8'h90);
  endtask

  task automatic t_clear_race();
    do_reset();
    wr(8'h88);
    frame();
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
    rd_chk("R7 ack clears", 8'h88);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h98; frame_start = 1'b1;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = 8'h00; frame_start = 1'b0;
    rd_chk("R8 set beats write clear", 8'h98);
    wr(8'h98);
    @(negedge clk);
    irq_ack = 1'b1; frame_start = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0; frame_start = 1'b0;
    rd_chk("R8 set beats ack", 8'h98);
  endtask

  task automatic t_unblank();
    do_reset();
    wr(8'h81);
    chk("R9 blank waits", {7'h0, blank_out}, 8'h00);
    frame();
    chk("R9 blank on", {7'h0, blank_out}, 8'h01);
    wr(8'h90);
    chk("R9 unblank waits", {7'h0, blank_out}, 8'h01);
    frame();
    chk("R9 unblank at frame", {7'h0, blank_out}, 8'h00);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_layout_enable();
        t_lowpower();
        t_clear_race();
        t_unblank();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule